// File: doc/BRIEF.md
# Two-level maskable interrupt controller

The block gathers 64 per-FIFO event pulses and eight miscellaneous event pulses. It holds them as sticky pending bits that a host reads through a small register port with an address, a read strobe, a write strobe and a byte of data. The FIFO pending bits sit in eight status bytes. One overview byte shows which of those bytes hold anything, so an interrupt routine reads the overview first and then only the banks that need service.

A read of a status byte returns its pending bits and clears exactly those bits. An event that arrives in the same cycle as that read stays pending. A FIFO event is recorded only if its own mask bit is set. A miscellaneous event is always recorded, and its mask only decides whether it drives the pin. A single registered, active-high interrupt output combines the enabled sources under a global enable.

Address map: 0x00..0x07 are FIFO status banks 0..7. 0x08 is the overview. 0x09 is the miscellaneous status. 0x0A is the miscellaneous mask. 0x0B is control, with bit 0 as the global enable and bit 1 as the FIFO enable. 0x10..0x17 are FIFO mask banks 0..7. FIFO source n maps to bank n/8, bit n%8. Read data is combinational and valid while the read strobe is high. Writes take effect at the clock edge.

Top module: `irq_hier_ctrl`

## Requirements
- R1: After reset all status, mask and control registers are zero, irq_o is low, and a read of any of them returns 0x00.
- R2: A pulse on fifo_evt_i[n] sets bank n/8 bit n%8 at the next clock edge only if mask bit n%8 at address 0x10+n/8 is set; otherwise the pulse is dropped.
- R3: Overview bit b at address 0x08 is 1 exactly when status bank b is nonzero, and reading the overview clears nothing.
- R4: Reading FIFO status bank b at address 0x00+b returns its bits and clears the returned bits at that clock edge.
- R5: Miscellaneous status at 0x09 records misc_evt_i regardless of the mask at 0x0A, and reading it clears the returned bits.
- R6: An event arriving in the same cycle as the read of its status register is still pending afterwards and is returned by the next read.
- R7: The miscellaneous mask (0x0A), control (0x0B, bit 0 global enable, bit 1 FIFO enable) and FIFO mask banks (0x10..0x17) are written by reg_wr_i and read back unchanged.
- R8: irq_o is registered and goes high one clock after the status holds a qualifying bit: global enable AND (any misc status bit with its mask set, OR FIFO enable AND any FIFO status bit).
- R9: With the global enable clear, irq_o is low one clock later whatever is pending.
- R10: With the FIFO enable clear, pending FIFO bits do not drive irq_o, while the bits stay pending and visible in the overview.
- R11: Writes to the status and overview addresses are ignored and change no pending bit.
- R12: Reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fifo_evt_i | input | 64 | Per-FIFO event pulses |
| misc_evt_i | input | 8 | Miscellaneous event pulses |
| addr_i | input | 5 | Register address |
| reg_rd_i | input | 1 | Read strobe; a status read clears at the edge |
| reg_wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while reg_rd_i is high |
| irq_o | output | 1 | Registered interrupt output, active high |

## Verification
The hardest case to reach is a clearing read that meets a new event on the same bit in the same cycle. The stimulus pulses the event input in the same vector that reads the register. It then reads the register again and expects the bit back. This is done on both the miscellaneous byte and the highest FIFO bank. It also checks that an overview read in between still shows that bank. A second case that is hard to reach is a pending FIFO bit held with the FIFO enable clear. The stimulus sets the bit, watches the pin stay low, and then sets the enable. The pin must rise exactly one clock after the enable takes effect.

// File: rtl/irq_hier_pkg.sv
package irq_hier_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_STAT_BASE = 5'h00;
  localparam logic [ADDR_W-1:0] ADDR_OVW       = 5'h08;
  localparam logic [ADDR_W-1:0] ADDR_MISC_ST   = 5'h09;
  localparam logic [ADDR_W-1:0] ADDR_MISC_MSK  = 5'h0A;
  localparam logic [ADDR_W-1:0] ADDR_CTRL      = 5'h0B;
  localparam logic [ADDR_W-1:0] ADDR_MASK_BASE = 5'h10;
  localparam int CTRL_GLB_BIT  = 0;
  localparam int CTRL_FIFO_BIT = 1;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] lat_en_i,
  input  logic         rd_clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] st_q;
  logic [W-1:0] clr_mask;

  // only the value being returned is cleared; new events win
  assign clr_mask = rd_clr_i ? st_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (st_q & ~clr_mask) | (evt_i & lat_en_i);
  end

  assign stat_o = st_q;
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_hier_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 8,
  localparam int NSRC     = NUM_BANKS * BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NSRC-1:0]   fifo_mask_o,
  output logic [DATA_W-1:0] misc_mask_o,
  output logic              glb_en_o,
  output logic              fifo_en_o
);
  logic [DATA_W-1:0] misc_mask_q;
  logic              glb_q, fen_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mask
    logic [BANK_W-1:0] m_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) m_q <= '0;
      else if (wr_i && addr_i == ADDR_MASK_BASE + ADDR_W'(b)) m_q <= wdata_i[BANK_W-1:0];
    end
    assign fifo_mask_o[b*BANK_W +: BANK_W] = m_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      misc_mask_q <= '0;
      glb_q       <= 1'b0;
      fen_q       <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == ADDR_MISC_MSK) misc_mask_q <= wdata_i;
      if (addr_i == ADDR_CTRL) begin
        glb_q <= wdata_i[CTRL_GLB_BIT];
        fen_q <= wdata_i[CTRL_FIFO_BIT];
      end
    end
  end

  assign misc_mask_o = misc_mask_q;
  assign glb_en_o    = glb_q;
  assign fifo_en_o   = fen_q;
endmodule

// File: rtl/irq_pin_gen.sv
module irq_pin_gen #(
  parameter int NSRC = 64,
  parameter int MW   = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] fifo_st_i,
  input  logic [MW-1:0]   misc_st_i,
  input  logic [MW-1:0]   misc_mask_i,
  input  logic            glb_en_i,
  input  logic            fifo_en_i,
  output logic            irq_o
);
  logic irq_q;
  logic req_d;

  assign req_d = glb_en_i & ((|(misc_st_i & misc_mask_i)) | (fifo_en_i & (|fifo_st_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= req_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_hier_ctrl.sv
module irq_hier_ctrl
  import irq_hier_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 8,
  localparam int NSRC     = NUM_BANKS * BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   fifo_evt_i,
  input  logic [DATA_W-1:0] misc_evt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [NSRC-1:0]      fifo_mask;
  logic [NSRC-1:0]      fifo_st;
  logic [NUM_BANKS-1:0] ovw;
  logic [DATA_W-1:0]    misc_mask;
  logic [DATA_W-1:0]    misc_st;
  logic                 glb_en, fifo_en;
  logic                 misc_clr;
  logic [DATA_W-1:0]    rd_mux;

  irq_cfg_regs #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .fifo_mask_o(fifo_mask),
    .misc_mask_o(misc_mask),
    .glb_en_o   (glb_en),
    .fifo_en_o  (fifo_en)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic clr;
    assign clr = reg_rd_i && (addr_i == ADDR_STAT_BASE + ADDR_W'(b));
    irq_status_bank #(.W(BANK_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (fifo_evt_i[b*BANK_W +: BANK_W]),
      .lat_en_i(fifo_mask[b*BANK_W +: BANK_W]),
      .rd_clr_i(clr),
      .stat_o  (fifo_st[b*BANK_W +: BANK_W])
    );
    assign ovw[b] = |fifo_st[b*BANK_W +: BANK_W];
  end

  assign misc_clr = reg_rd_i && (addr_i == ADDR_MISC_ST);

  // misc events latch regardless of mask
  irq_status_bank #(.W(DATA_W)) u_misc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (misc_evt_i),
    .lat_en_i({DATA_W{1'b1}}),
    .rd_clr_i(misc_clr),
    .stat_o  (misc_st)
  );

  irq_pin_gen #(.NSRC(NSRC), .MW(DATA_W)) u_pin (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fifo_st_i  (fifo_st),
    .misc_st_i  (misc_st),
    .misc_mask_i(misc_mask),
    .glb_en_i   (glb_en),
    .fifo_en_i  (fifo_en),
    .irq_o      (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr_i == ADDR_STAT_BASE + ADDR_W'(b))
        rd_mux = DATA_W'(fifo_st[b*BANK_W +: BANK_W]);
      if (addr_i == ADDR_MASK_BASE + ADDR_W'(b))
        rd_mux = DATA_W'(fifo_mask[b*BANK_W +: BANK_W]);
    end
    case (addr_i)
      ADDR_OVW:      rd_mux = DATA_W'(ovw);
      ADDR_MISC_ST:  rd_mux = misc_st;
      ADDR_MISC_MSK: rd_mux = misc_mask;
      ADDR_CTRL: begin
        rd_mux = '0;
        rd_mux[CTRL_GLB_BIT]  = glb_en;
        rd_mux[CTRL_FIFO_BIT] = fifo_en;
      end
      default: ;
    endcase
  end

  assign rdata_o = reg_rd_i ? rd_mux : '0;
endmodule

// File: rtl/irq_hier_ctrl_chk.sv
module irq_hier_ctrl_chk
  import irq_hier_pkg::*;
#(
  parameter int NSRC = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NSRC-1:0]   fifo_evt_i,
  input logic [DATA_W-1:0] misc_evt_i,
  input logic [NSRC-1:0]   fifo_st,
  input logic [NSRC-1:0]   fifo_mask,
  input logic [DATA_W-1:0] misc_st,
  input logic [DATA_W-1:0] misc_mask,
  input logic              glb_en,
  input logic              fifo_en,
  input logic              irq_o
);
  a_r9_glb_off_pin_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en |=> !irq_o);

  a_r10_fifo_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en && ((misc_st & misc_mask) == '0)) |=> !irq_o);

  a_r2_unmasked_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((fifo_st & ~$past(fifo_st) & ~$past(fifo_evt_i & fifo_mask)) == '0));

  a_r3_ovw_read_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && addr_i == ADDR_OVW) |=> ((fifo_st & $past(fifo_st)) == $past(fifo_st)));

  a_r6_fifo_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((fifo_st & $past(fifo_evt_i & fifo_mask)) == $past(fifo_evt_i & fifo_mask)));

  a_r6_misc_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((misc_st & $past(misc_evt_i)) == $past(misc_evt_i)));

  a_r11_no_clear_without_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |=> (((fifo_st & $past(fifo_st)) == $past(fifo_st)) &&
                   ((misc_st & $past(misc_st)) == $past(misc_st))));
endmodule

bind irq_hier_ctrl irq_hier_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reg_rd_i  (reg_rd_i),
  .addr_i    (addr_i),
  .fifo_evt_i(fifo_evt_i),
  .misc_evt_i(misc_evt_i),
  .fifo_st   (fifo_st),
  .fifo_mask (fifo_mask),
  .misc_st   (misc_st),
  .misc_mask (misc_mask),
  .glb_en    (glb_en),
  .fifo_en   (fifo_en),
  .irq_o     (irq_o)
);

// File: tb/irq_hier_ctrl_bench.sv
module irq_hier_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] fifo_evt = '0;
  logic [7:0]  misc_evt = '0;
  logic [4:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  irq_hier_ctrl u_irq_hier_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .fifo_evt_i(fifo_evt), .misc_evt_i(misc_evt),
    .addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  // {req[3:0], op[1:0] (0 idle,1 wr,2 rd), addr[4:0], data/expect[7:0], fevt[63:0], mevt[7:0], exp_irq}
  localparam int NV = 44;
  localparam logic [91:0] VECS [NV] = '{
    {4'd1, 2'd0, 5'h00, 8'h00, 64'h0, 8'h00, 1'b0},  // R1 idle after reset
    {4'd1, 2'd2, 5'h0B, 8'h00, 64'h0, 8'h00, 1'b0},  // R1 ctrl zero
    {4'd7, 2'd1, 5'h10, 8'h01, 64'h0, 8'h00, 1'b0},  // R7 mask fifo0
    {4'd7, 2'd1, 5'h0B, 8'h03, 64'h0, 8'h00, 1'b0},  // R7 enables on
    {4'd2, 2'd0, 5'h00, 8'h00, 64'h3, 8'h00, 1'b0},  // R2 fifo0 masked in, fifo1 dropped
    {4'd8, 2'd0, 5'h00, 8'h00, 64'h0, 8'h00, 1'b0},  // R8 pin not yet up
    {4'd3, 2'd2, 5'h08, 8'h01, 64'h0, 8'h00, 1'b1},  // R3 overview
    {4'd2, 2'd2, 5'h00, 8'h01, 64'h0, 8'h00, 1'b1},  // R2 R4 bank0 read clears
    {4'd3, 2'd2, 5'h08, 8'h00, 64'h0, 8'h00, 1'b1},  // R3
    {4'd8, 2'd0, 5'h00, 8'h00, 64'h0, 8'h00, 1'b0},  // R8 pin down
    {4'd5, 2'd0, 5'h00, 8'h00, 64'h0, 8'h81, 1'b0},  // R5 misc with mask 0
    {4'd5, 2'd2, 5'h09, 8'h81, 64'h0, 8'h80, 1'b0},  // R5 R6 read with same-cycle event
    {4'd6, 2'd2, 5'h09, 8'h80, 64'h0, 8'h00, 1'b0},  // R6 event kept
    {4'd5, 2'd2, 5'h09, 8'h00, 64'h0, 8'h00, 1'b0},  // R5 cleared
    {4'd7, 2'd1, 5'h0A, 8'h04, 64'h0, 8'h00, 1'b0},  // R7 misc mask
    {4'd8, 2'd0, 5'h00, 8'h00, 64'h0, 8'h04, 1'b0},
    {4'd8, 2'd0, 5'h00, 8'h00, 64'h0, 8'h00, 1'b0},
    {4'd8, 2'd0, 5'h00, 8'h00, 64'h0, 8'h00, 1'b1},  // R8 misc drives pin
    {4'd9, 2'd1, 5'h0B, 8'h02, 64'h0, 8'h00, 1'b1},  // R9 global off
    {4'd9, 2'd0, 5'h00, 8'h00, 64'h0, 8'h00, 1'b1},
    {4'd9, 2'd0, 5'h00, 8'h00, 64'h0, 8'h00, 1'b0},
    {4'd5, 2'd2, 5'h09, 8'h04, 64'h0, 8'h00, 1'b0},
    {4'd10, 2'd1, 5'h0B, 8'h01, 64'h0, 8'h00, 1'b0}, // R10 fifo enable off
    {4'd10, 2'd0, 5'h00, 8'h00, 64'h1, 8'h00, 1'b0},
    {4'd10, 2'd0, 5'h00, 8'h00, 64'h0, 8'h00, 1'b0},
    {4'd10, 2'd0, 5'h00, 8'h00, 64'h0, 8'h00, 1'b0},
    {4'd3, 2'd2, 5'h08, 8'h01, 64'h0, 8'h00, 1'b0},  // R3 R10 still pending
    {4'd10, 2'd1, 5'h0B, 8'h03, 64'h0, 8'h00, 1'b0},
    {4'd10, 2'd0, 5'h00, 8'h00, 64'h0, 8'h00, 1'b0},
    {4'd10, 2'd0, 5'h00, 8'h00, 64'h0, 8'h00, 1'b1},
    {4'd11, 2'd1, 5'h00, 8'h00, 64'h0, 8'h00, 1'b1}, // R11 status write ignored
    {4'd4, 2'd2, 5'h00, 8'h01, 64'h0, 8'h00, 1'b1},  // R4 R11
    {4'd8, 2'd0, 5'h00, 8'h00, 64'h0, 8'h00, 1'b1},
    {4'd8, 2'd0, 5'h00, 8'h00, 64'h0, 8'h00, 1'b0},
    {4'd7, 2'd1, 5'h17, 8'h80, 64'h0, 8'h00, 1'b0},  // R7 mask fifo63
    {4'd2, 2'd0, 5'h00, 8'h00, 64'hC000_0000_0000_0000, 8'h00, 1'b0},
    {4'd7, 2'd2, 5'h17, 8'h80, 64'h0, 8'h00, 1'b0},
    {4'd6, 2'd2, 5'h07, 8'h80, 64'h8000_0000_0000_0000, 8'h00, 1'b1}, // R6 bank7
    {4'd6, 2'd2, 5'h08, 8'h80, 64'h0, 8'h00, 1'b1},
    {4'd6, 2'd2, 5'h07, 8'h80, 64'h0, 8'h00, 1'b1},
    {4'd3, 2'd2, 5'h08, 8'h00, 64'h0, 8'h00, 1'b1},
    {4'd8, 2'd0, 5'h00, 8'h00, 64'h0, 8'h00, 1'b0},
    {4'd12, 2'd2, 5'h1F, 8'h00, 64'h0, 8'h00, 1'b0}, // R12 unmapped
    {4'd7, 2'd2, 5'h0A, 8'h04, 64'h0, 8'h00, 1'b0}
  };

  task automatic check(input string what, input int req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  // read during current cycle, no clock advance
  task automatic peek(input logic [4:0] a, input logic [7:0] exp, input int req);
    @(negedge clk);
    fifo_evt = '0; misc_evt = '0; wr = 1'b0;
    rd = 1'b1; addr = a;
    #1;
    check("read", req, rdata, exp);
  endtask

  initial begin
    // R1 reset state, read while in reset
    peek(5'h0B, 8'h00, 1);
    check("irq in reset", 1, {7'd0, irq}, 8'h00);
    @(negedge clk);
    rd = 1'b0;
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [91:0] v;
      v = VECS[i];
      @(negedge clk);
      fifo_evt = v[72:9];
      misc_evt = v[8:1];
      addr     = v[85:81];
      wdata    = v[80:73];
      wr       = (v[87:86] == 2'd1);
      rd       = (v[87:86] == 2'd2);
      #1;
      if (v[87:86] == 2'd2) check($sformatf("vec %0d rdata", i), int'(v[91:88]), rdata, v[80:73]);
      check($sformatf("vec %0d irq", i), int'(v[91:88]), {7'd0, irq}, {7'd0, v[0]});
    end

    // R1: reset in mid-run clears pending state and config
    @(negedge clk);
    rd = 1'b0; wr = 1'b1; addr = 5'h0B; wdata = 8'h03;
    @(negedge clk);
    wr = 1'b0; misc_evt = 8'h04;
    @(negedge clk);
    misc_evt = 8'h00;
    @(negedge clk);
    check("irq before reset", 8, {7'd0, irq}, 8'h01);
    rst_ni = 1'b0;
    #1;
    check("irq after reset", 1, {7'd0, irq}, 8'h00);
    peek(5'h09, 8'h00, 1);
    peek(5'h0A, 8'h00, 1);
    peek(5'h17, 8'h00, 1);
    peek(5'h10, 8'h00, 1);
    @(negedge clk);
    rd = 1'b0;
    rst_ni = 1'b1;
    peek(5'h0B, 8'h00, 1);
    @(negedge clk);
    rd = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule